// File: doc/BRIEF.md
# LIN Break and Sync Field Receiver

This block is the front end of a LIN slave that sits ahead of a normal UART receiver. While idle with its receive path off, it treats a falling edge on the serial line as a wakeup and turns the receive path on in break-reception mode. It then times the next low period of the bus in bit times, sampling at mid-bit with the current bit divisor. A long enough low run counts as a break field and raises a one-cycle completion pulse. A short one is reported as a break error, and the block keeps waiting for a proper break.

After a valid break, a capture counter times the sync byte 0x55 that follows. The span from its first falling edge to its fifth is eight bit times. That span divided by eight is presented as the measured bit period with a one-cycle strobe, so that software can reprogram the baud divisor. The block then switches its own receive path off.

While the block owns the line, the normal UART error checks are masked and the receive shift register image stays at all ones. Identifier, data and checksum fields are handled elsewhere.

Top module: `lin_break_sync_rx`

## Requirements
- R1: After synchronous reset `rx_enable`, `break_mode`, `err_mask`, `brk_done`, `brk_err`, `sync_timeout` and `period_valid` are 0, `period_out` is 0 and `shift_image` is 8'hFF.
- R2: In idle with `enable` high, a falling edge on `rx_in` (seen after a two-flop synchronizer) sets `rx_enable` and `break_mode`. With `enable` low the same edge leaves `rx_enable` at 0.
- R3: In break mode, the low run that follows a falling edge is sampled every `bit_div` clocks, with the first sample half a bit in. When the first high sample shows a count of 11 or more low samples, `brk_done` pulses for exactly one cycle, `break_mode` drops and `rx_enable` stays high.
- R4: When the first high sample shows fewer than 11 low samples, `brk_err` pulses for one cycle, `brk_done` stays low and `break_mode` stays high. `brk_done`, `brk_err`, `sync_timeout` and `period_valid` are never high together.
- R5: The low-sample count saturates at 15, so a low run of 20 bit times is still a valid break.
- R6: While `rx_enable` is high, `err_mask` is 1 and `shift_image` stays 8'hFF.
- R7: The capture counter starts at `brk_done`. `period_out` becomes the number of clocks between the first and fifth falling edges of the sync byte (0x55 sent LSB first with a start and a stop bit), divided by 8. It is marked by a one-cycle `period_valid`.
- R8: The cycle after `period_valid`, `rx_enable` is 0, and `period_out` holds its value after that.
- R9: If the capture counter reaches 2^CAP_W-1 before the fifth falling edge, `sync_timeout` pulses for one cycle and the block returns to break mode, ready for a new break.
- R10: `enable` low forces the block to idle with `rx_enable` at 0 on the next cycle, and cancels any sync measurement in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Block enable; low forces idle |
| rx_in | input | 1 | Asynchronous LIN serial input, idle high |
| bit_div | input | DIV_W | Current clocks per bit |
| rx_enable | output | 1 | Receive path on |
| break_mode | output | 1 | Waiting for or timing a break field |
| err_mask | output | 1 | Suppress UART overrun, parity and framing errors |
| shift_image | output | 8 | Receive shift register image |
| brk_done | output | 1 | One-cycle pulse: valid break received |
| brk_err | output | 1 | One-cycle pulse: low run too short |
| sync_timeout | output | 1 | One-cycle pulse: sync field not completed in time |
| period_valid | output | 1 | One-cycle strobe for `period_out` |
| period_out | output | CAP_W-2 | Measured bit period in clocks |

## Verification
The hardest case to reach is the sync timeout, because the capture counter has to run to its full count with fewer than five edges seen. The bench builds the block with a narrow capture counter and holds the line high after a valid break, so that the timeout arrives within a few thousand cycles. A new break then shows that break mode is back. Counter saturation is reached with a 20-bit low run. The 10-bit and 11-bit runs sit on either side of the threshold, with half a bit of margin at each mid-bit sample.

// File: rtl/lin_brk_pkg.sv
package lin_brk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_LOW  = 2'd2,
        ST_SYNC = 2'd3
    } lin_state_e;

    // Minimum low samples for a valid break
    localparam int unsigned BREAK_MIN_BITS = 11;
    // Width of the saturating low-sample counter (saturates at 15)
    localparam int unsigned LOW_CNT_W      = 4;
    // Falling edges that bound the measured span of the sync byte
    localparam int unsigned SYNC_FALLS     = 5;
    // log2 of the bit times between the first and last counted falling edges
    localparam int unsigned SYNC_SPAN_SH   = 3;
    // Reset image of the receive shift register
    localparam logic [7:0]  SHIFT_IDLE     = 8'hFF;

endpackage

// File: rtl/lin_rx_sync.sv
module lin_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_in,
    output logic rx_s,
    output logic fall
);

    logic [STAGES-1:0] sh_d, sh_q;
    logic              prev_d, prev_q;

    always_comb begin
        sh_d   = {sh_q[STAGES-2:0], rx_in};
        prev_d = sh_q[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '1;
            prev_q <= 1'b1;
        end else begin
            sh_q   <= sh_d;
            prev_q <= prev_d;
        end
    end

    assign rx_s = sh_q[STAGES-1];
    assign fall = prev_q & ~sh_q[STAGES-1];

endmodule

// File: rtl/lin_bit_sampler.sv
module lin_bit_sampler #(
    parameter int DIV_W = 16,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             run,
    input  logic             rx_s,
    input  logic [DIV_W-1:0] bit_div,
    output logic             tick,
    output logic [CNT_W-1:0] low_bits
);

    localparam logic [CNT_W-1:0] LOW_MAX = '1;

    typedef struct packed {
        logic [DIV_W-1:0] tmr;
        logic [CNT_W-1:0] low;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d = smp_q;
        tick  = run && (smp_q.tmr == '0);
        if (start) begin
            smp_d.tmr = bit_div >> 1;   // first sample lands half a bit in
            smp_d.low = '0;
        end else if (run) begin
            if (smp_q.tmr == '0) begin
                smp_d.tmr = bit_div - 1'b1;
                if (!rx_s && smp_q.low != LOW_MAX)
                    smp_d.low = smp_q.low + 1'b1;
            end else begin
                smp_d.tmr = smp_q.tmr - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) smp_q <= '0;
        else     smp_q <= smp_d;
    end

    assign low_bits = smp_q.low;

endmodule

// File: rtl/lin_sync_capture.sv
module lin_sync_capture #(
    parameter int CAP_W   = 20,
    parameter int PER_W   = 18,
    parameter int FALLS   = 5,
    parameter int SPAN_SH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             abort,
    input  logic             fall,
    output logic             done,
    output logic             timeout,
    output logic [PER_W-1:0] period
);

    localparam int               EW      = $clog2(FALLS + 1);
    localparam logic [EW-1:0]    LAST_E  = EW'(FALLS - 1);
    localparam logic [CAP_W-1:0] CAP_MAX = '1;

    typedef struct packed {
        logic             armed;
        logic [EW-1:0]    edges;
        logic [CAP_W-1:0] cap;
        logic             done;
        logic             tmo;
        logic [PER_W-1:0] per;
    } cap_t;

    cap_t     c_d, c_q;
    logic [CAP_W:0] cap_inc;

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        c_d.tmo  = 1'b0;
        cap_inc  = {1'b0, c_q.cap} + 1'b1;
        if (abort) begin
            c_d.armed = 1'b0;
        end else if (start) begin
            c_d.armed = 1'b1;
            c_d.edges = '0;
            c_d.cap   = '0;
        end else if (c_q.armed) begin
            if (fall && c_q.edges == LAST_E) begin
                c_d.done  = 1'b1;
                c_d.per   = PER_W'(cap_inc >> SPAN_SH);
                c_d.armed = 1'b0;
                c_d.edges = '0;
            end else if (c_q.cap == CAP_MAX) begin
                c_d.tmo   = 1'b1;
                c_d.armed = 1'b0;
            end else begin
                if (fall)
                    c_d.edges = c_q.edges + 1'b1;
                if (fall && c_q.edges == '0)
                    c_d.cap = '0;           // span starts at the first edge
                else
                    c_d.cap = cap_inc[CAP_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) c_q <= '0;
        else     c_q <= c_d;
    end

    assign done    = c_q.done;
    assign timeout = c_q.tmo;
    assign period  = c_q.per;

endmodule

// File: rtl/lin_break_sync_rx.sv
module lin_break_sync_rx
    import lin_brk_pkg::*;
#(
    parameter int DIV_W       = 16,
    parameter int CAP_W       = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  logic               rx_in,
    input  logic [DIV_W-1:0]   bit_div,
    output logic               rx_enable,
    output logic               break_mode,
    output logic               err_mask,
    output logic [7:0]         shift_image,
    output logic               brk_done,
    output logic               brk_err,
    output logic               sync_timeout,
    output logic               period_valid,
    output logic [CAP_W-3:0]   period_out
);

    localparam int PER_W = CAP_W - 2;
    localparam int CNT_W = LOW_CNT_W;
    localparam logic [CNT_W-1:0] MIN_LOW = CNT_W'(BREAK_MIN_BITS);

    typedef struct packed {
        lin_state_e st;
        logic       done;
        logic       err;
        logic [7:0] shift;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             rx_s, fall;
    logic             smp_tick;
    logic [CNT_W-1:0] low_bits;
    logic             smp_start, cap_start, cap_abort;
    logic             cap_done, cap_tmo;
    logic [PER_W-1:0] cap_per;

    lin_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .rx_in (rx_in),
        .rx_s  (rx_s),
        .fall  (fall)
    );

    lin_bit_sampler #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_smp (
        .clk      (clk),
        .rst      (rst),
        .start    (smp_start),
        .run      (ctl_q.st == ST_LOW),
        .rx_s     (rx_s),
        .bit_div  (bit_div),
        .tick     (smp_tick),
        .low_bits (low_bits)
    );

    lin_sync_capture #(
        .CAP_W   (CAP_W),
        .PER_W   (PER_W),
        .FALLS   (SYNC_FALLS),
        .SPAN_SH (SYNC_SPAN_SH)
    ) u_cap (
        .clk     (clk),
        .rst     (rst),
        .start   (cap_start),
        .abort   (cap_abort),
        .fall    (fall),
        .done    (cap_done),
        .timeout (cap_tmo),
        .period  (cap_per)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.done  = 1'b0;
        ctl_d.err   = 1'b0;
        ctl_d.shift = SHIFT_IDLE;   // data path stays parked while this block owns the line
        smp_start   = 1'b0;
        cap_start   = 1'b0;
        cap_abort   = !enable;
        if (!enable) begin
            ctl_d.st = ST_IDLE;
        end else begin
            unique case (ctl_q.st)
                ST_IDLE: if (fall) ctl_d.st = ST_ARM;
                ST_ARM: begin
                    if (fall) begin
                        ctl_d.st  = ST_LOW;
                        smp_start = 1'b1;
                    end
                end
                ST_LOW: begin
                    if (smp_tick && rx_s) begin
                        if (low_bits >= MIN_LOW) begin
                            ctl_d.done = 1'b1;
                            ctl_d.st   = ST_SYNC;
                            cap_start  = 1'b1;
                        end else begin
                            ctl_d.err = 1'b1;
                            ctl_d.st  = ST_ARM;
                        end
                    end
                end
                ST_SYNC: begin
                    if (cap_done)     ctl_d.st = ST_IDLE;
                    else if (cap_tmo) ctl_d.st = ST_ARM;
                end
                default: ctl_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.st    <= ST_IDLE;
            ctl_q.done  <= 1'b0;
            ctl_q.err   <= 1'b0;
            ctl_q.shift <= SHIFT_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rx_enable    = (ctl_q.st != ST_IDLE);
    assign break_mode   = (ctl_q.st == ST_ARM) || (ctl_q.st == ST_LOW);
    assign err_mask     = (ctl_q.st != ST_IDLE);
    assign shift_image  = ctl_q.shift;
    assign brk_done     = ctl_q.done;
    assign brk_err      = ctl_q.err;
    assign sync_timeout = cap_tmo;
    assign period_valid = cap_done;
    assign period_out   = cap_per;

endmodule

// File: rtl/lin_break_sync_rx_chk.sv
module lin_break_sync_rx_chk (
    input logic clk,
    input logic rst,
    input logic enable,
    input logic rx_enable,
    input logic break_mode,
    input logic brk_done,
    input logic brk_err,
    input logic sync_timeout,
    input logic period_valid
);

    assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
        brk_done |=> !brk_done);

    assert_done_to_sync_R3: assert property (@(posedge clk) disable iff (rst)
        brk_done |-> (rx_enable && !break_mode));

    assert_err_rearms_R4: assert property (@(posedge clk) disable iff (rst)
        brk_err |-> break_mode);

    assert_events_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({brk_done, brk_err, sync_timeout, period_valid}));

    assert_period_release_R8: assert property (@(posedge clk) disable iff (rst)
        (period_valid && enable) |=> !rx_enable);

    assert_timeout_rearms_R9: assert property (@(posedge clk) disable iff (rst)
        (sync_timeout && enable) |=> break_mode);

    assert_disable_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !rx_enable);

endmodule

bind lin_break_sync_rx lin_break_sync_rx_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .enable       (enable),
    .rx_enable    (rx_enable),
    .break_mode   (break_mode),
    .brk_done     (brk_done),
    .brk_err      (brk_err),
    .sync_timeout (sync_timeout),
    .period_valid (period_valid)
);

// File: tb/tb_lin_break_sync_rx.sv
`timescale 1ns/1ps
module tb_lin_break_sync_rx;

    localparam int DIV_W = 16;
    localparam int CAP_W = 12;
    localparam int PER_W = CAP_W - 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             enable = 1'b0;
    logic             rx_in = 1'b1;
    logic [DIV_W-1:0] bit_div = 16'd16;
    logic             rx_enable, break_mode, err_mask;
    logic [7:0]       shift_image;
    logic             brk_done, brk_err, sync_timeout, period_valid;
    logic [PER_W-1:0] period_out;

    int n_chk = 0;
    int n_fail = 0;
    int n_done = 0, n_err = 0, n_tmo = 0, n_val = 0;
    int bitd = 16;
    bit finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    lin_break_sync_rx #(.DIV_W(DIV_W), .CAP_W(CAP_W)) dut (
        .clk          (clk),
        .rst          (rst),
        .enable       (enable),
        .rx_in        (rx_in),
        .bit_div      (bit_div),
        .rx_enable    (rx_enable),
        .break_mode   (break_mode),
        .err_mask     (err_mask),
        .shift_image  (shift_image),
        .brk_done     (brk_done),
        .brk_err      (brk_err),
        .sync_timeout (sync_timeout),
        .period_valid (period_valid),
        .period_out   (period_out)
    );

    always @(negedge clk) begin
        if (brk_done)     n_done++;
        if (brk_err)      n_err++;
        if (sync_timeout) n_tmo++;
        if (period_valid) n_val++;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_bit(input int d);
        bitd    = d;
        bit_div = DIV_W'(d);
    endtask

    task automatic send_low(input int nbits);
        rx_in = 1'b0;
        wait_cyc(nbits * bitd);
        rx_in = 1'b1;
    endtask

    task automatic send_byte(input logic [7:0] b);
        rx_in = 1'b0;
        wait_cyc(bitd);
        for (int i = 0; i < 8; i++) begin
            rx_in = b[i];
            wait_cyc(bitd);
        end
        rx_in = 1'b1;
        wait_cyc(bitd);
    endtask

    task automatic t_reset();
        wait_cyc(6);
        rst = 1'b0;
        wait_cyc(2);
        check("R1 rx_enable", rx_enable, 0);
        check("R1 break_mode", break_mode, 0);
        check("R1 err_mask", err_mask, 0);
        check("R1 shift_image", shift_image, 8'hFF);
        check("R1 period_out", period_out, 0);
        check("R1 pulses", {brk_done, brk_err, sync_timeout, period_valid}, 0);
    endtask

    task automatic t_no_enable();
        enable = 1'b0;
        send_low(1);
        wait_cyc(2 * bitd);
        check("R2 edge ignored without enable", rx_enable, 0);
        check("R10 idle while disabled", break_mode, 0);
    endtask

    task automatic t_wakeup();
        enable = 1'b1;
        send_low(1);
        wait_cyc(2 * bitd);
        check("R2 wakeup rx_enable", rx_enable, 1);
        check("R2 wakeup break_mode", break_mode, 1);
        check("R6 err_mask in break", err_mask, 1);
    endtask

    task automatic t_break(input int nbits, input bit ok);
        int d0 = n_done;
        int e0 = n_err;
        send_low(nbits);
        wait_cyc(2 * bitd);
        if (ok) begin
            check("R3 one brk_done", n_done - d0, 1);
            check("R3 no brk_err", n_err - e0, 0);
            check("R3 left break mode", break_mode, 0);
            check("R3 rx_enable kept", rx_enable, 1);
        end else begin
            check("R4 one brk_err", n_err - e0, 1);
            check("R4 no brk_done", n_done - d0, 0);
            check("R4 still break mode", break_mode, 1);
        end
        check("R6 shift_image held", shift_image, 8'hFF);
    endtask

    task automatic t_sync();
        int v0 = n_val;
        send_byte(8'h55);
        wait_cyc(2 * bitd);
        check("R7 one period_valid", n_val - v0, 1);
        check("R7 period_out", period_out, bitd);
        check("R8 rx_enable off", rx_enable, 0);
        wait_cyc(3 * bitd);
        check("R8 period_out held", period_out, bitd);
    endtask

    task automatic t_timeout();
        int t0 = n_tmo;
        int d0;
        wait_cyc(4200);
        check("R9 one sync_timeout", n_tmo - t0, 1);
        check("R9 back in break mode", break_mode, 1);
        check("R9 no period_valid", period_valid, 0);
        d0 = n_done;
        send_low(13);
        wait_cyc(2 * bitd);
        check("R9 new break accepted", n_done - d0, 1);
    endtask

    task automatic t_disable_mid_sync();
        int v0 = n_val;
        enable = 1'b0;
        wait_cyc(2);
        check("R10 disable forces idle", rx_enable, 0);
        send_byte(8'h55);
        wait_cyc(2 * bitd);
        check("R10 sync cancelled", n_val - v0, 0);
        check("R10 remains idle", rx_enable, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        set_bit(16);
        t_no_enable();
        t_wakeup();
        t_break(8, 1'b0);    // R4 short run
        t_break(10, 1'b0);   // R4 one below the threshold
        t_break(11, 1'b1);   // R3 at the threshold
        t_sync();            // R7 R8 with 16 clocks per bit
        t_wakeup();
        t_break(20, 1'b1);   // R5 saturation keeps a long run valid
        t_sync();
        set_bit(24);
        t_wakeup();
        t_break(13, 1'b1);
        t_sync();            // R7 with 24 clocks per bit
        t_wakeup();
        t_break(12, 1'b1);
        t_timeout();         // R9
        t_disable_mid_sync(); // R10
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule